// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that finishes every instruction between one rising clock edge and the next. It runs a small integer subset: four logic and arithmetic register operations, a signed set-on-less-than, word load and store, branch-on-equal and an absolute jump. Each cycle the word at the program counter is read from an instruction store. Its fields pick two source registers. The ALU, the data store and the next-address logic then settle combinationally, and the clock edge commits the register write, the memory write and the new program counter together.

Program and data live in two separate internal word arrays, because an instruction read and a data access happen in the same cycle. A surrounding harness fills both arrays through a single loading write port, normally while the core is held in reset. Three groups of trace outputs let the harness follow execution: the current program counter, the register write that commits at the next edge, and the data-store write that commits at the next edge.

Top module: `cpu_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and all 32 registers read 0. Writes from the core are suppressed during reset. The first instruction after release is fetched from byte address 0.
- R2: Every instruction except branch (opcode 6'h04) and jump (opcode 6'h02) advances the program counter by 4. The program counter always stays word-aligned. The instruction at byte address A is word A/4 of the instruction store.
- R3: Opcode 6'h00 with shamt 0 writes register rd with rs+rt (funct 6'h20), rs−rt (funct 6'h22), rs AND rt (funct 6'h24) or rs OR rt (funct 6'h25). Fields: op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0].
- R4: Funct 6'h2A writes rd with 1 when rs is less than rt as signed 32-bit values, and with 0 otherwise. The result is correct when rs−rt overflows.
- R5: Load (opcode 6'h23) writes register rt with the data word at rs + sign-extended offset[15:0]. Negative offsets work.
- R6: Store (opcode 6'h2B) writes rt to the data word at rs + sign-extended offset. A store writes no register.
- R7: Branch (opcode 6'h04) sets the program counter to PC+4 + (sign-extended offset × 4) when rs equals rt, and to PC+4 otherwise. Backward targets work.
- R8: Jump (opcode 6'h02) sets the program counter to {(PC+4)[31:28], address[25:0], 2'b00}.
- R9: Register 0 reads as zero and ignores writes.
- R10: Any other opcode, any unknown funct, or a non-zero shamt executes as a no-op. It writes nothing and only advances the program counter.
- R11: A load that directly follows a store to the same address returns the stored value.
- R12: `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` show the register write that commits at the next edge. `dm_we_o`, `dm_addr_o` and `dm_wdata_o` show the data write that commits at the next edge. The address and data outputs are meaningful only while their enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Loader write strobe |
| load_sel | input | 1 | Loader target: 0 instruction store, 1 data store |
| load_addr | input | LOAD_AW | Loader word index |
| load_data | input | 32 | Loader write word |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written to that register |
| dm_we_o | output | 1 | A data-store write commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Word being stored |

## Verification
The hardest cases to reach are the ones that depend on register contents built up earlier. A taken branch and a backward branch need a register pair made equal by earlier loads and arithmetic. Register 0 being ignored and registers being cleared on reset can only be seen when a later store copies them out. The stimulus is a single program whose data words are preloaded. Its branch and jump targets skip over filler instructions that would show up as register writes if they were ever executed. The per-cycle trace is compared with a table worked out by hand. A second, short program runs after a reset in the middle of the run. It stores a register that held a value before that reset, and it tests signed comparison at the overflow boundary.

// File: rtl/cpu_pkg.sv
// Package cpu_pkg
// Shared opcode values, ALU operation codes and the control word that the
// decoder hands to the datapath. Assumes the fixed 32-bit word and the
// field layout of the instruction subset.
package cpu_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    // Control word: one bit per steering decision.
    typedef struct packed {
        logic    reg_write;   // commit a register write
        logic    dst_is_rd;   // destination from rd (else rt)
        logic    b_is_imm;    // ALU second operand is the extended offset
        logic    mem_write;   // commit a data-store write
        logic    wb_from_mem; // writeback from data store (else ALU)
        logic    branch;      // conditional branch on equality
        logic    jump;        // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_decode.sv
// Module cpu_decode
// Combinational main and ALU control decoder. It turns the opcode, funct
// and shamt fields into a control word. Unsupported encodings give an
// all-inactive word, so the instruction only advances the program counter.
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output ctrl_t      ctrl
);

    logic    fn_known;
    alu_op_e fn_op;

    // Map the funct field to an ALU operation for register-format words.
    always_comb begin
        fn_known = 1'b1;
        fn_op    = ALU_ADD;
        unique case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: fn_known = 1'b0;
        endcase
    end

    // Build the control word from the opcode.
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
                 mem_write: 1'b0, wb_from_mem: 1'b0, branch: 1'b0,
                 jump: 1'b0, alu_op: ALU_ADD};
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.reg_write = fn_known && (shamt == 5'd0);
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = fn_op;
            end
            OP_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.b_is_imm  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
// Module cpu_alu
// Combinational ALU for add, subtract, and, or and signed set-less-than,
// with a zero flag used for the equality branch. The signed compare is
// done directly, not from the sign of the difference, so overflow of
// a-b cannot corrupt it.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the result of the requested operation.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/cpu_regfile.sv
// Module cpu_regfile
// Register file with two combinational read ports and one write port
// that commits on the rising edge. Entry 0 is hard-wired to zero: it
// reads zero and never stores. Synchronous active-low reset clears all
// entries.
module cpu_regfile #(
    parameter int W     = 32,
    parameter int COUNT = 32,
    localparam int AW   = $clog2(COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [COUNT];

    // Clear on reset, otherwise store into a non-zero entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/cpu_wordmem.sv
// Module cpu_wordmem
// Word-wide storage array with one combinational read port and one
// clocked write port. Contents are not reset; the harness loads them.
module cpu_wordmem #(
    parameter int W  = 32,
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Commit a write on the rising edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cpu_core.sv
// Module cpu_core
// Single-cycle processor core. The program counter register, the register
// file and the two word stores are the only state; everything between
// them settles in one cycle. Two adders beside the ALU produce PC+4 and
// the branch target. Assumes word-aligned data addresses and that the
// loader is used only while the core is held in reset.
module cpu_core
    import cpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_we,
    input  logic               load_sel,
    input  logic [LOAD_AW-1:0] load_addr,
    input  logic [XLEN-1:0]    load_data,
    output logic [XLEN-1:0]    pc_o,
    output logic               rf_we_o,
    output logic [4:0]         rf_waddr_o,
    output logic [XLEN-1:0]    rf_wdata_o,
    output logic               dm_we_o,
    output logic [XLEN-1:0]    dm_addr_o,
    output logic [XLEN-1:0]    dm_wdata_o
);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] mem_rdata;
    logic [XLEN-1:0] wb_data;
    logic [4:0]      dst;
    logic            alu_zero;
    logic            take_branch;
    logic            rf_we;
    logic            dm_core_we;
    logic            dm_we;
    logic [DMEM_AW-1:0] dm_waddr;
    logic [XLEN-1:0]    dm_wdata;
    ctrl_t           ctrl;

    // Program counter register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    cpu_wordmem #(.W(XLEN), .AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (load_we && !load_sel),
        .waddr (load_addr[IMEM_AW-1:0]),
        .wdata (load_data),
        .raddr (pc[IMEM_AW+1:2]),
        .rdata (instr)
    );

    cpu_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .shamt  (instr[10:6]),
        .ctrl   (ctrl)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign dst     = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign rf_we   = ctrl.reg_write && rst_n && (dst != 5'd0);

    cpu_regfile #(.W(XLEN), .COUNT(REG_COUNT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (instr[25:21]),
        .ra_b  (instr[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (rf_we),
        .wa    (dst),
        .wd    (wb_data)
    );

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    cpu_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: the loader has priority over core writes.
    assign dm_core_we = ctrl.mem_write && rst_n;
    assign dm_we      = dm_core_we || (load_we && load_sel);
    assign dm_waddr   = (load_we && load_sel) ? load_addr[DMEM_AW-1:0]
                                              : alu_y[DMEM_AW+1:2];
    assign dm_wdata   = (load_we && load_sel) ? load_data : rt_val;

    cpu_wordmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (mem_rdata)
    );

    assign wb_data = ctrl.wb_from_mem ? mem_rdata : alu_y;

    // Next-address logic: two dedicated adders and the jump concatenation.
    assign pc_plus4    = pc + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_branch = ctrl.branch && alu_zero;

    // Choose the next program counter.
    always_comb begin
        if (ctrl.jump)        pc_next = jmp_target;
        else if (take_branch) pc_next = br_target;
        else                  pc_next = pc_plus4;
    end

    assign pc_o       = pc;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = dst;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_core_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

endmodule

// File: rtl/cpu_core_chk.sv
// Module cpu_core_chk
// Property checker bound to cpu_core. It checks next-address behaviour,
// register 0 protection and write exclusivity against the fetched word.
module cpu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        dm_we
);

    logic [5:0]  op;
    logic [31:0] seq_pc;
    logic [31:0] off4;
    logic        known_op;

    assign op       = instr[31:26];
    assign seq_pc   = pc + 32'd4;
    assign off4     = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign known_op = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) ||
                      (op == 6'h04) || (op == 6'h02);

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == 32'd0));

    p_pc_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 6'h04 && op != 6'h02) |=> (pc == $past(pc) + 32'd4));

    p_beq_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h04 && rs_val == rt_val) |=> (pc == $past(seq_pc) + $past(off4)));

    p_beq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h04 && rs_val != rt_val) |=> (pc == $past(seq_pc)));

    p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h02) |=> (pc == {$past(seq_pc[31:28]), $past(instr[25:0]), 2'b00}));

    p_no_r0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0));

    p_store_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> (op == 6'h2B && !rf_we));

    p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind cpu_core cpu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .rf_we    (rf_we_o),
    .rf_waddr (rf_waddr_o),
    .dm_we    (dm_we_o)
);

// File: tb/cpu_core_bench.sv
// Bench for cpu_core: loads a program, then compares the per-cycle trace
// with a hand-derived table, then runs directed reset and compare cases.
module cpu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    cpu_core u_cpu_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_we    (load_we),
        .load_sel   (load_sel),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] a);
        return {6'h02, a};
    endfunction

    localparam logic [31:0] FILL = {6'h00, 5'd1, 5'd1, 5'd11, 5'd0, 6'h20};

    localparam logic [31:0] PROG [27] = '{
        enc_i(6'h23, 5'd0, 5'd1, 16'd0),       // 0  r1 = mem[0]
        enc_i(6'h23, 5'd0, 5'd2, 16'd4),       // 1  r2 = mem[4]
        enc_r(5'd1, 5'd2, 5'd3, 6'h20),        // 2  add
        enc_r(5'd1, 5'd2, 5'd4, 6'h22),        // 3  sub
        enc_r(5'd1, 5'd2, 5'd5, 6'h24),        // 4  and
        enc_r(5'd1, 5'd2, 5'd6, 6'h25),        // 5  or
        enc_r(5'd2, 5'd1, 5'd7, 6'h2A),        // 6  slt -3<5
        enc_r(5'd1, 5'd2, 5'd8, 6'h2A),        // 7  slt 5<-3
        enc_i(6'h2B, 5'd0, 5'd4, 16'd12),      // 8  sw r4 -> 12
        enc_i(6'h23, 5'd4, 5'd9, 16'hFFFC),    // 9  lw r9, -4(r4)
        enc_i(6'h23, 5'd4, 5'd10, 16'd4),      // 10 lw r10, 4(r4)
        enc_r(5'd1, 5'd1, 5'd0, 6'h20),        // 11 add into r0
        enc_i(6'h2B, 5'd0, 5'd0, 16'd16),      // 12 sw r0 -> 16
        enc_i(6'h04, 5'd1, 5'd2, 16'd5),       // 13 beq not taken
        enc_i(6'h04, 5'd9, 5'd2, 16'd1),       // 14 beq taken -> 16
        FILL,                                  // 15
        enc_j(26'd20),                         // 16 j -> 20
        FILL, FILL, FILL,                      // 17..19
        {6'h3F, 26'h0000123},                  // 20 unknown opcode
        enc_i(6'h04, 5'd0, 5'd0, 16'd1),       // 21 beq -> 23
        enc_j(26'd25),                         // 22 j -> 25
        enc_i(6'h04, 5'd0, 5'd0, 16'hFFFE),    // 23 beq back -> 22
        FILL,                                  // 24
        enc_i(6'h2B, 5'd0, 5'd7, 16'd20),      // 25 sw r7 -> 20
        enc_j(26'd26)                          // 26 self loop
    };

    typedef struct packed {
        logic [31:0] pc;
        logic        rwe;
        logic [4:0]  rwa;
        logic [31:0] rwd;
        logic        dwe;
        logic [31:0] da;
        logic [31:0] dd;
        logic [3:0]  req;
    } trace_t;

    localparam trace_t TRACE [23] = '{
        '{32'h00, 1'b1, 5'd1,  32'h5,        1'b0, 32'h0,  32'h0, 4'd5},  // R5
        '{32'h04, 1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'h0,  32'h0, 4'd5},  // R5
        '{32'h08, 1'b1, 5'd3,  32'h2,        1'b0, 32'h0,  32'h0, 4'd3},  // R3
        '{32'h0C, 1'b1, 5'd4,  32'h8,        1'b0, 32'h0,  32'h0, 4'd3},  // R3
        '{32'h10, 1'b1, 5'd5,  32'h5,        1'b0, 32'h0,  32'h0, 4'd3},  // R3
        '{32'h14, 1'b1, 5'd6,  32'hFFFFFFFD, 1'b0, 32'h0,  32'h0, 4'd3},  // R3
        '{32'h18, 1'b1, 5'd7,  32'h1,        1'b0, 32'h0,  32'h0, 4'd4},  // R4
        '{32'h1C, 1'b1, 5'd8,  32'h0,        1'b0, 32'h0,  32'h0, 4'd4},  // R4
        '{32'h20, 1'b0, 5'd0,  32'h0,        1'b1, 32'hC,  32'h8, 4'd6},  // R6
        '{32'h24, 1'b1, 5'd9,  32'hFFFFFFFD, 1'b0, 32'h0,  32'h0, 4'd5},  // R5
        '{32'h28, 1'b1, 5'd10, 32'h8,        1'b0, 32'h0,  32'h0, 4'd11}, // R11
        '{32'h2C, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd9},  // R9
        '{32'h30, 1'b0, 5'd0,  32'h0,        1'b1, 32'h10, 32'h0, 4'd9},  // R9
        '{32'h34, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd7},  // R7
        '{32'h38, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd7},  // R7
        '{32'h40, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd7},  // R7
        '{32'h50, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd8},  // R8
        '{32'h54, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd10}, // R10
        '{32'h5C, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd7},  // R7
        '{32'h58, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd7},  // R7
        '{32'h64, 1'b0, 5'd0,  32'h0,        1'b1, 32'h14, 32'h1, 4'd8},  // R8
        '{32'h68, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd12}, // R12
        '{32'h68, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0, 4'd8}   // R8
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
        load_sel  = sel;
        load_addr = 6'(addr);
        load_data = data;
        load_we   = 1'b1;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 27; i++) load_word(1'b0, i, PROG[i]);
        load_word(1'b1, 0, 32'h0000_0005);
        load_word(1'b1, 1, 32'hFFFF_FFFD);
        load_word(1'b1, 2, 32'h1234_5678);
        // R1: program counter held at zero in reset
        check("R1", "pc in reset", pc_o, 32'h0);
        check("R1", "no register write in reset", {31'd0, rf_we_o}, 32'd0);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < 23; k++) begin
            string tag;
            tag = $sformatf("R%0d", TRACE[k].req);
            check(tag, $sformatf("pc step %0d", k), pc_o, TRACE[k].pc);
            check(tag, $sformatf("rf_we step %0d", k), {31'd0, rf_we_o}, {31'd0, TRACE[k].rwe});
            if (TRACE[k].rwe) begin
                check(tag, $sformatf("rf_waddr step %0d", k), {27'd0, rf_waddr_o}, {27'd0, TRACE[k].rwa});
                check(tag, $sformatf("rf_wdata step %0d", k), rf_wdata_o, TRACE[k].rwd);
            end
            check(tag, $sformatf("dm_we step %0d", k), {31'd0, dm_we_o}, {31'd0, TRACE[k].dwe});
            if (TRACE[k].dwe) begin
                check(tag, $sformatf("dm_addr step %0d", k), dm_addr_o, TRACE[k].da);
                check(tag, $sformatf("dm_wdata step %0d", k), dm_wdata_o, TRACE[k].dd);
            end
            @(negedge clk);
            #1;
        end

        // Directed: reset during a run clears PC and registers (R1),
        // and signed compare across the overflow boundary (R4).
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc_o, 32'h0);
        load_word(1'b0, 0, enc_i(6'h2B, 5'd0, 5'd1, 16'd28));
        load_word(1'b0, 1, enc_i(6'h23, 5'd0, 5'd2, 16'd32));
        load_word(1'b0, 2, enc_i(6'h23, 5'd0, 5'd3, 16'd36));
        load_word(1'b0, 3, enc_r(5'd2, 5'd3, 5'd4, 6'h2A));
        load_word(1'b0, 4, enc_r(5'd3, 5'd2, 5'd5, 6'h2A));
        load_word(1'b0, 5, enc_j(26'd5));
        load_word(1'b1, 8, 32'h8000_0000);
        load_word(1'b1, 9, 32'h7FFF_FFFF);
        rst_n = 1'b1;
        #1;
        check("R1", "store of cleared r1 enable", {31'd0, dm_we_o}, 32'd1);
        check("R1", "store of cleared r1 data", dm_wdata_o, 32'h0);
        check("R6", "store address", dm_addr_o, 32'd28);
        @(negedge clk); #1;
        check("R5", "load min value", rf_wdata_o, 32'h8000_0000);
        @(negedge clk); #1;
        check("R5", "load max value", rf_wdata_o, 32'h7FFF_FFFF);
        @(negedge clk); #1;
        check("R4", "slt min<max overflow case", rf_wdata_o, 32'h1);
        check("R4", "slt dest", {27'd0, rf_waddr_o}, 32'd4);
        @(negedge clk); #1;
        check("R4", "slt max<min", rf_wdata_o, 32'h0);
        @(negedge clk); #1;
        check("R8", "self jump pc", pc_o, 32'h14);
        @(negedge clk); #1;
        check("R8", "self jump holds", pc_o, 32'h14);
        check("R2", "pc aligned", {30'd0, pc_o[1:0]}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule